// File: doc/BRIEF.md
# Two-Wire Serial Bus Event Monitor

This block listens to a two-wire serial bus (one clock line, one data line) without ever driving it. Both lines are sampled by a much faster system clock. Each line passes through a synchronizer chain, and a copy of the previous synchronized value is kept, so that edges and bus conditions can be recognised from consecutive samples. The block finds start, repeated start and stop conditions. It gathers each nine-bit frame into a byte and its acknowledge bit, and reports what it found as a stream of single-cycle events.

The first frame after a start is reported as an address event, with the direction flag carried in the byte. Every later frame is a data event, until the next start or stop. If a start or stop arrives before a frame is complete, the partial frame is thrown away and nothing is reported for it. Clock pulses that arrive before any start are not decoded. A typical use is a debug or trace capture path that records bus traffic next to other on-chip events.

Top module: `twowire_monitor`

## Requirements
- R1: A falling data line while the clock line is high produces a START event (evKind = 0) in any state, and framing restarts with the address frame.
- R2: A rising data line while the clock line is high produces a STOP event (evKind = 1) and returns the monitor to idle.
- R3: A repeated start, given without a stop after earlier frames, is reported as START, and the frame that follows is reported as an address again.
- R4: Bits are taken on rising edges of the clock line, most significant bit first, so evByte[7] holds the first bit of a frame.
- R5: The ninth bit of a frame is reported on evNack: 0 for an acknowledge (low line), 1 for a not-acknowledge (high line).
- R6: The first complete frame after a start is an ADDR event (evKind = 2). evByte[7:1] carries the 7-bit address and evByte[0] the direction: 0 write, 1 read.
- R7: Every complete frame after the address frame, until the next start or stop, is a DATA event (evKind = 3) carrying the byte.
- R8: Rising clock edges seen while idle (after reset or after a stop) produce no event.
- R9: A start or stop that arrives in the middle of a frame discards the partial bits. No ADDR or DATA event is produced for them.
- R10: Each event is a valid pulse one cycle long. Bus conditions are detected before bit sampling when both happen in the same cycle.
- R11: Synchronous reset clears evValid and returns the monitor to idle, so a frame clocked after reset without a start produces nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous reset, active high |
| busClkIn | input | 1 | Bus clock line as observed (asynchronous) |
| busDatIn | input | 1 | Bus data line as observed (asynchronous) |
| evValid | output | 1 | One-cycle pulse marking a reported event |
| evKind | output | 2 | Event kind: 0 START, 1 STOP, 2 ADDR, 3 DATA |
| evByte | output | BYTE_W | Frame byte for ADDR and DATA, zero for START and STOP |
| evNack | output | 1 | Ninth-bit value for ADDR and DATA, 1 means not acknowledged |

## Verification
The bench builds the block with its default values: a two-stage synchronizer and eight-bit frames. With these values the detection delay is three system clocks, well inside the four-clock hold the bench gives each bus phase, so every event can be matched to the bus action that caused it. Eight-bit frames let byte patterns such as 0x80 and 0x01 expose any error in bit order. The two-stage chain also gives a mid-frame reset a short window in which partial bits could leak through.

// File: rtl/twm_pkg.sv
package twm_pkg;

  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_STOP  = 2'd1,
    EV_ADDR  = 2'd2,
    EV_DATA  = 2'd3
  } evKind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } monState_e;

  // strobes from control to the frame datapath
  typedef struct packed {
    logic clearFrame;
    logic shiftBit;
  } frameCmd_t;

endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rawClk,
  input  logic rawDat,
  output logic lineDat,
  output logic clkRise,
  output logic startCond,
  output logic stopCond
);

  logic [STAGES-1:0] clkChain;
  logic [STAGES-1:0] datChain;
  logic clkPrev;
  logic datPrev;
  logic clkNow;

  // synchronizer stages; idle bus level (high) after reset
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          clkChain[g] <= 1'b1;
          datChain[g] <= 1'b1;
        end else begin
          clkChain[g] <= rawClk;
          datChain[g] <= rawDat;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          clkChain[g] <= 1'b1;
          datChain[g] <= 1'b1;
        end else begin
          clkChain[g] <= clkChain[g-1];
          datChain[g] <= datChain[g-1];
        end
      end
    end
  end

  assign clkNow  = clkChain[STAGES-1];
  assign lineDat = datChain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      clkPrev <= 1'b1;
      datPrev <= 1'b1;
    end else begin
      clkPrev <= clkNow;
      datPrev <= lineDat;
    end
  end

  assign clkRise   = ~clkPrev & clkNow;
  assign startCond = clkNow & datPrev & ~lineDat;
  assign stopCond  = clkNow & ~datPrev & lineDat;

endmodule

// File: rtl/twm_frame_dp.sv
module twm_frame_dp
  import twm_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  frameCmd_t         cmd,
  input  logic              bitIn,
  output logic [BYTE_W-1:0] shiftData,
  output logic [CNT_W-1:0]  bitCount
);

  always_ff @(posedge clk) begin
    if (rst || cmd.clearFrame) begin
      shiftData <= '0;
      bitCount  <= '0;
    end else if (cmd.shiftBit) begin
      bitCount <= bitCount + 1'b1;
      if (bitCount < CNT_W'(BYTE_W)) begin
        shiftData <= {shiftData[BYTE_W-2:0], bitIn};
      end
    end
  end

endmodule

// File: rtl/twm_seq_ctrl.sv
module twm_seq_ctrl
  import twm_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clkRise,
  input  logic              startCond,
  input  logic              stopCond,
  input  logic              lineDat,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic [BYTE_W-1:0] shiftData,
  output frameCmd_t         cmd,
  output logic              evValid,
  output logic [1:0]        evKind,
  output logic [BYTE_W-1:0] evByte,
  output logic              evNack
);

  monState_e state, stateNext;
  logic fire;
  evKind_e kindNext;
  logic [BYTE_W-1:0] byteNext;
  logic nackNext;

  always_comb begin
    cmd       = '0;
    stateNext = state;
    fire      = 1'b0;
    kindNext  = EV_START;
    byteNext  = '0;
    nackNext  = 1'b0;
    if (startCond) begin
      cmd.clearFrame = 1'b1;
      stateNext      = ST_ADDR;
      fire           = 1'b1;
      kindNext       = EV_START;
    end else if (stopCond) begin
      cmd.clearFrame = 1'b1;
      stateNext      = ST_IDLE;
      fire           = 1'b1;
      kindNext       = EV_STOP;
    end else if (clkRise && state != ST_IDLE) begin
      if (bitCount == CNT_W'(BYTE_W)) begin
        // ninth bit: acknowledge slot closes the frame
        cmd.clearFrame = 1'b1;
        fire           = 1'b1;
        kindNext       = (state == ST_ADDR) ? EV_ADDR : EV_DATA;
        byteNext       = shiftData;
        nackNext       = lineDat;
        stateNext      = ST_DATA;
      end else begin
        cmd.shiftBit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      evValid <= 1'b0;
      evKind  <= 2'd0;
      evByte  <= '0;
      evNack  <= 1'b0;
    end else begin
      state   <= stateNext;
      evValid <= fire;
      if (fire) begin
        evKind <= kindNext;
        evByte <= byteNext;
        evNack <= nackNext;
      end
    end
  end

endmodule

// File: rtl/twowire_monitor.sv
module twowire_monitor
  import twm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busClkIn,
  input  logic              busDatIn,
  output logic              evValid,
  output logic [1:0]        evKind,
  output logic [BYTE_W-1:0] evByte,
  output logic              evNack
);

  localparam int CNT_W = $clog2(BYTE_W + 2);

  logic lineDat;
  logic clkRise;
  logic startCond;
  logic stopCond;
  frameCmd_t cmd;
  logic [BYTE_W-1:0] shiftData;
  logic [CNT_W-1:0] bitCount;

  twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .rawClk    (busClkIn),
    .rawDat    (busDatIn),
    .lineDat   (lineDat),
    .clkRise   (clkRise),
    .startCond (startCond),
    .stopCond  (stopCond)
  );

  twm_frame_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .bitIn     (lineDat),
    .shiftData (shiftData),
    .bitCount  (bitCount)
  );

  twm_seq_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .clkRise   (clkRise),
    .startCond (startCond),
    .stopCond  (stopCond),
    .lineDat   (lineDat),
    .bitCount  (bitCount),
    .shiftData (shiftData),
    .cmd       (cmd),
    .evValid   (evValid),
    .evKind    (evKind),
    .evByte    (evByte),
    .evNack    (evNack)
  );

endmodule

// File: rtl/twm_checker.sv
module twm_checker #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              startCond,
  input logic              stopCond,
  input logic              clkRise,
  input logic              evValid,
  input logic [1:0]        evKind,
  input logic [BYTE_W-1:0] evByte
);

  logic awaitAddr;
  logic inData;

  always_ff @(posedge clk) begin
    if (rst) begin
      awaitAddr <= 1'b0;
      inData    <= 1'b0;
    end else if (evValid) begin
      case (evKind)
        2'd0: begin awaitAddr <= 1'b1; inData <= 1'b0; end
        2'd1: begin awaitAddr <= 1'b0; inData <= 1'b0; end
        2'd2: begin awaitAddr <= 1'b0; inData <= 1'b1; end
        default: ;
      endcase
    end
  end

  // R1
  a_r1_start_reported: assert property (@(posedge clk) disable iff (rst)
    startCond |=> (evValid && evKind == 2'd0));

  // R2
  a_r2_stop_reported: assert property (@(posedge clk) disable iff (rst)
    (stopCond && !startCond) |=> (evValid && evKind == 2'd1));

  // R6
  a_r6_addr_after_start: assert property (@(posedge clk) disable iff (rst)
    (evValid && evKind == 2'd2) |-> awaitAddr);

  // R7
  a_r7_data_after_addr: assert property (@(posedge clk) disable iff (rst)
    (evValid && evKind == 2'd3) |-> inData);

  // R9, R10: a frame event needs a clock rise with no bus condition beside it
  a_r9_frame_on_plain_rise: assert property (@(posedge clk) disable iff (rst)
    (evValid && evKind[1]) |-> ($past(clkRise) && !$past(startCond) && !$past(stopCond)));

  // R11
  a_r11_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> !evValid);

  // R6: a start or stop carries no byte
  a_r6_cond_empty_byte: assert property (@(posedge clk) disable iff (rst)
    (evValid && !evKind[1]) |-> (evByte == '0));

endmodule

bind twowire_monitor twm_checker #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .startCond (startCond),
  .stopCond  (stopCond),
  .clkRise   (clkRise),
  .evValid   (evValid),
  .evKind    (evKind),
  .evByte    (evByte)
);

// File: tb/test_twowire_monitor.sv
module test_twowire_monitor;

  localparam int HOLD   = 4;
  localparam int NVEC   = 16;
  localparam int MAXEV  = 64;

  // entry: [14:12] action (0 start, 1 byte, 2 stop, 3 three partial bits),
  //        [11:4] byte, [3] ninth bit, [2] event expected, [1:0] expected kind
  localparam logic [14:0] VEC [0:NVEC-1] = '{
    {3'd0, 8'h00, 1'b0, 1'b1, 2'd0},
    {3'd1, 8'hA4, 1'b0, 1'b1, 2'd2},
    {3'd1, 8'h3C, 1'b0, 1'b1, 2'd3},
    {3'd1, 8'hFF, 1'b1, 1'b1, 2'd3},
    {3'd0, 8'h00, 1'b0, 1'b1, 2'd0},
    {3'd1, 8'hA5, 1'b0, 1'b1, 2'd2},
    {3'd1, 8'h01, 1'b1, 1'b1, 2'd3},
    {3'd2, 8'h00, 1'b0, 1'b1, 2'd1},
    {3'd1, 8'h77, 1'b0, 1'b0, 2'd0},
    {3'd0, 8'h00, 1'b0, 1'b1, 2'd0},
    {3'd3, 8'h00, 1'b0, 1'b0, 2'd0},
    {3'd0, 8'h00, 1'b0, 1'b1, 2'd0},
    {3'd1, 8'h80, 1'b1, 1'b1, 2'd2},
    {3'd3, 8'h00, 1'b0, 1'b0, 2'd0},
    {3'd2, 8'h00, 1'b0, 1'b1, 2'd1},
    {3'd1, 8'h5A, 1'b0, 1'b0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic busClk = 1'b1;
  logic busDat = 1'b1;
  logic evValid;
  logic [1:0] evKind;
  logic [7:0] evByte;
  logic evNack;

  int total = 0;
  int bad = 0;
  int evCount = 0;
  bit lastValid = 1'b0;
  bit done = 1'b0;
  int cycles = 0;
  logic [1:0] recKind [MAXEV];
  logic [7:0] recByte [MAXEV];
  logic       recNack [MAXEV];

  always #2 clk = ~clk;

  twowire_monitor i_twowire_monitor (
    .clk      (clk),
    .rst      (rst),
    .busClkIn (busClk),
    .busDatIn (busDat),
    .evValid  (evValid),
    .evKind   (evKind),
    .evByte   (evByte),
    .evNack   (evNack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // event recorder and pulse-width check (R10)
  always @(negedge clk) begin
    cycles++;
    if (!rst && evValid && lastValid) begin
      total++;
      bad++;
      $display("FAIL R10 actual=%0d expected=%0d (valid held two cycles)", 1, 0);
    end
    lastValid = evValid;
    if (!rst && evValid && evCount < MAXEV) begin
      recKind[evCount] = evKind;
      recByte[evCount] = evByte;
      recNack[evCount] = evNack;
      evCount++;
    end
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    busClk = 1'b0; waitCyc(HOLD);
    busDat = 1'b1; waitCyc(HOLD);
    busClk = 1'b1; waitCyc(HOLD);
    busDat = 1'b0; waitCyc(HOLD);
    busClk = 1'b0; waitCyc(HOLD);
  endtask

  task automatic busStop();
    busClk = 1'b0; waitCyc(HOLD);
    busDat = 1'b0; waitCyc(HOLD);
    busClk = 1'b1; waitCyc(HOLD);
    busDat = 1'b1; waitCyc(HOLD);
  endtask

  task automatic busBit(input logic b);
    busDat = b;    waitCyc(HOLD);
    busClk = 1'b1; waitCyc(HOLD);
    busClk = 1'b0; waitCyc(HOLD);
  endtask

  task automatic busByte(input logic [7:0] v, input logic ackBit);
    busClk = 1'b0; waitCyc(HOLD);
    for (int i = 7; i >= 0; i--) busBit(v[i]);
    busBit(ackBit);
  endtask

  task automatic busPartial();
    busClk = 1'b0; waitCyc(HOLD);
    busBit(1'b1);
    busBit(1'b0);
    busBit(1'b1);
  endtask

  initial begin
    waitCyc(5);
    chk(evValid == 1'b0, "R11 reset valid", int'(evValid), 0);
    rst = 1'b0;
    waitCyc(5);
    chk(evCount == 0, "R11 quiet after reset", evCount, 0);

    // table walk: R1..R10
    for (int k = 0; k < NVEC; k++) begin
      int base;
      logic [2:0] act;
      logic [7:0] val;
      logic ackBit, emit;
      logic [1:0] kind;
      base   = evCount;
      act    = VEC[k][14:12];
      val    = VEC[k][11:4];
      ackBit = VEC[k][3];
      emit   = VEC[k][2];
      kind   = VEC[k][1:0];
      case (act)
        3'd0: busStart();
        3'd1: busByte(val, ackBit);
        3'd2: busStop();
        default: busPartial();
      endcase
      waitCyc(8);
      // R8 and R9 for entries with no event; R1/R2/R3 for conditions
      chk(evCount - base == int'(emit), $sformatf("R1/R2/R8/R9 vec%0d count", k),
          evCount - base, int'(emit));
      if (emit && evCount > base) begin
        chk(recKind[base] == kind, $sformatf("R3/R6/R7 vec%0d kind", k),
            int'(recKind[base]), int'(kind));
        if (kind[1]) begin
          chk(recByte[base] == val, $sformatf("R4 vec%0d byte", k),
              int'(recByte[base]), int'(val));
          chk(recNack[base] == ackBit, $sformatf("R5 vec%0d ack", k),
              int'(recNack[base]), int'(ackBit));
        end
      end
    end

    // R6: direction bit in bit 0 of the address byte (0xA5 -> read, addr 0x52)
    chk(recByte[5][0] == 1'b1, "R6 read flag", int'(recByte[5][0]), 1);
    chk(recByte[5][7:1] == 7'h52, "R6 address", int'(recByte[5][7:1]), 'h52);

    // R11: reset in mid-frame returns to idle
    begin
      int base;
      busStart();
      busPartial();
      rst = 1'b1;
      waitCyc(3);
      chk(evValid == 1'b0, "R11 valid in reset", int'(evValid), 0);
      rst = 1'b0;
      waitCyc(4);
      base = evCount;
      busByte(8'hC3, 1'b0);
      waitCyc(8);
      chk(evCount == base, "R11 idle after reset", evCount - base, 0);
      busStart();
      busByte(8'h42, 1'b0);
      waitCyc(8);
      chk(evCount - base == 2, "R11 restart count", evCount - base, 2);
      chk(recKind[base + 1] == 2'd2, "R11 restart addr kind", int'(recKind[base + 1]), 2);
      chk(recByte[base + 1] == 8'h42, "R11 restart addr byte", int'(recByte[base + 1]), 'h42);
      busStop();
      waitCyc(8);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule